// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block walks through the elements of one vectorised integer add. A start pulse loads the vector length, the sub-vector lane count, the predicate mask, the condition-result enable, the lane-fold select and three register base indices. From the next cycle it issues one lane operation per cycle. Each operation drives two combinational register read addresses, adds the two 64-bit operands with wrap-around, and drives a register write of the sum unless the predicate bit of that sub-vector is clear.

One predicate bit covers every source lane and the destination of a sub-vector. With the condition-result enable set, the sign and zero tests of all lanes of a sub-vector are folded with a bitwise AND or OR into one 4-bit condition field. That field is written at index 8 plus the element number. A source step and a destination step counter run in lock-step and are visible at the ports, so a loop that was stopped can be restarted from a saved step. No overflow or carry summary is kept or updated.

Top module: `vec_elem_seq`

## Requirements
- R1: With `pred_en_i` low at start, every element is treated as enabled, whatever `pred_mask_i` holds.
- R2: With `pred_en_i` high, element i uses bit i of the mask latched at start. When that bit is 0, none of the element's lane cycles has `wr_en_o` or `cr_we_o` high, but the element still takes its lane cycles and the steps still advance.
- R3: `src_step_o` and `dst_step_o` are equal in every cycle. While busy they show the element being processed, and they rise by one after each element's last lane cycle.
- R4: Start begins the loop at element `resume_step_i`. Elements below that index produce no write and take no cycles.
- R5: Lane l of element i drives the read addresses `ra+i*N+l` and `rb+i*N+l` and writes the sum, modulo 2^64, to `rt+i*N+l`. N is the lane count, and addresses wrap at the register index width.
- R6: With `rc_en_i` high, an enabled element writes its condition field once, at index 8+i, in its last lane cycle. With `rc_en_i` low, no condition field is ever written.
- R7: Condition field bits are: [3] lt, set for a negative signed sum; [2] gt, set for a positive signed sum; [1] eq, set for a zero sum; [0] so, always 0.
- R8: With more than one lane, each lt/gt/eq bit is the AND of the lane tests when `fold_and_i` was high at start, and the OR otherwise.
- R9: `done_o` is high for exactly one cycle. That cycle follows the last lane cycle of element VL-1, or directly follows the start cycle if `resume_step_i >= vl_i`. The steps read 0 in the done cycle and stay 0 until the next start.
- R10: `subvl_i` encodes the lane count minus one: 0 gives 1 lane, and 1, 2 and 3 give 2, 3 and 4 lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| vl_i | input | VL_W | Vector length in sub-vectors |
| subvl_i | input | 2 | Lane count minus one |
| resume_step_i | input | STEP_W | First element to process |
| pred_en_i | input | 1 | Use the predicate mask |
| pred_mask_i | input | MAX_VL | One bit per sub-vector |
| rc_en_i | input | 1 | Write condition fields |
| fold_and_i | input | 1 | 1: AND-fold lane tests, 0: OR-fold |
| ra_base_i | input | REG_AW | First operand base register |
| rb_base_i | input | REG_AW | Second operand base register |
| rt_base_i | input | REG_AW | Destination base register |
| rd_a_addr_o | output | REG_AW | First read address |
| rd_a_data_i | input | DATA_W | First read data (combinational) |
| rd_b_addr_o | output | REG_AW | Second read address |
| rd_b_data_i | input | DATA_W | Second read data (combinational) |
| wr_en_o | output | 1 | Register write enable |
| wr_addr_o | output | REG_AW | Register write address |
| wr_data_o | output | DATA_W | Register write data |
| cr_we_o | output | 1 | Condition field write enable |
| cr_idx_o | output | CR_AW | Condition field index |
| cr_val_o | output | 4 | {lt, gt, eq, so} |
| src_step_o | output | STEP_W | Source step |
| dst_step_o | output | STEP_W | Destination step |
| busy_o | output | 1 | Loop in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench targets an empty loop (VL of zero, or a resume step at or beyond VL). A sequencer that ran such a loop anyway would emit stray writes, or would leave done low one cycle too long. It also drives sums that are exactly zero, sums that are negative and mixed lanes under both fold modes: a swapped AND/OR, or a test read as unsigned, shows up as wrong lt/gt/eq bits. Masked-off sub-vectors and resumed loops check that the steps keep advancing without writes, and that the steps stay equal. The mask and options are scrambled after start, which exposes a design that uses the live inputs instead of the latched ones.

// File: rtl/vec_elem_seq_pkg.sv
package vec_elem_seq_pkg;
   localparam int CR_BITS = 4;
   // condition field layout: [3] lt, [2] gt, [1] eq, [0] so
   typedef logic [CR_BITS-1:0] cr_field_t;
   localparam int CR_LT = 3;
   localparam int CR_GT = 2;
   localparam int CR_EQ = 1;
   localparam int CR_SO = 0;
endpackage

// File: rtl/vec_elem_step_ctrl.sv
module vec_elem_step_ctrl #(
   parameter int MAX_VL = 64,
   parameter int VL_W   = $clog2(MAX_VL + 1),
   parameter int STEP_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [VL_W-1:0]   vl_i,
   input  logic [1:0]        lanes_m1_i,
   input  logic [STEP_W-1:0] resume_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [STEP_W-1:0] src_o,
   output logic [STEP_W-1:0] dst_o,
   output logic [1:0]        lane_o,
   output logic [1:0]        lanes_m1_o,
   output logic              first_lane_o,
   output logic              last_lane_o
);
   localparam int CW = ((VL_W > STEP_W) ? VL_W : STEP_W) + 1;
   localparam logic [CW-1:0] MAX_C = CW'(MAX_VL);

   logic              busy_q, done_q;
   logic [STEP_W-1:0] src_q, dst_q;
   logic [1:0]        lane_q, lanes_q;
   logic [CW-1:0]     vl_q;
   logic [CW-1:0]     vl_eff, resume_c, next_c;
   logic              last_elem;

   always_comb begin
      vl_eff    = (CW'(vl_i) > MAX_C) ? MAX_C : CW'(vl_i);
      resume_c  = CW'(resume_i);
      next_c    = CW'(src_q) + CW'(1);
      last_elem = (next_c == vl_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         src_q   <= '0;
         dst_q   <= '0;
         lane_q  <= '0;
         lanes_q <= '0;
         vl_q    <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q && start_i) begin
            vl_q    <= vl_eff;
            lanes_q <= lanes_m1_i;
            lane_q  <= '0;
            if (resume_c < vl_eff) begin
               busy_q <= 1'b1;
               src_q  <= resume_i;
               dst_q  <= resume_i;
            end else begin
               done_q <= 1'b1;
               src_q  <= '0;
               dst_q  <= '0;
            end
         end else if (busy_q) begin
            if (lane_q != lanes_q) begin
               lane_q <= lane_q + 2'd1;
            end else begin
               lane_q <= '0;
               if (last_elem) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
                  src_q  <= '0;
                  dst_q  <= '0;
               end else begin
                  src_q <= src_q + STEP_W'(1);
                  dst_q <= dst_q + STEP_W'(1);
               end
            end
         end
      end
   end

   assign busy_o       = busy_q;
   assign done_o       = done_q;
   assign src_o        = src_q;
   assign dst_o        = dst_q;
   assign lane_o       = lane_q;
   assign lanes_m1_o   = lanes_q;
   assign first_lane_o = (lane_q == 2'd0);
   assign last_lane_o  = (lane_q == lanes_q);

   a_r3_steps_equal: assert property (@(posedge clk) disable iff (!rst_n)
      src_q == dst_q);
   a_r3_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && last_lane_o && !last_elem) |=> (src_q == $past(src_q) + STEP_W'(1)));
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   a_r9_done_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (!busy_q && src_q == '0));
endmodule

// File: rtl/vec_elem_lane_test.sv
module vec_elem_lane_test
   import vec_elem_seq_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] sum_i,
   output cr_field_t         test_o
);
   always_comb begin
      test_o         = '0;
      test_o[CR_EQ]  = (sum_i == '0);
      test_o[CR_LT]  = sum_i[DATA_W-1];
      test_o[CR_GT]  = !sum_i[DATA_W-1] && (sum_i != '0);
      test_o[CR_SO]  = 1'b0;
   end

   always_comb begin
      if (!$isunknown(sum_i)) begin
         a_r7_one_test: assert ($onehot({test_o[CR_LT], test_o[CR_GT], test_o[CR_EQ]}));
      end
   end
endmodule

// File: rtl/vec_elem_fold.sv
module vec_elem_fold
   import vec_elem_seq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      adv_i,
   input  logic      first_i,
   input  logic      and_i,
   input  cr_field_t test_i,
   output cr_field_t fold_o
);
   cr_field_t acc_q;

   for (genvar b = 0; b < CR_BITS; b++) begin : g_bit
      if (b == CR_SO) begin : g_so
         assign fold_o[b] = 1'b0;
      end else begin : g_test
         assign fold_o[b] = first_i ? test_i[b]
                          : (and_i ? (acc_q[b] & test_i[b]) : (acc_q[b] | test_i[b]));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_q <= '0;
      else if (adv_i) acc_q <= fold_o;
   end
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
   import vec_elem_seq_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int REG_AW = 7,
   parameter int MAX_VL = 64,
   parameter int VL_W   = $clog2(MAX_VL + 1),
   parameter int STEP_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1,
   parameter int CR_AW  = $clog2(MAX_VL + 8)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [VL_W-1:0]   vl_i,
   input  logic [1:0]        subvl_i,
   input  logic [STEP_W-1:0] resume_step_i,
   input  logic              pred_en_i,
   input  logic [MAX_VL-1:0] pred_mask_i,
   input  logic              rc_en_i,
   input  logic              fold_and_i,
   input  logic [REG_AW-1:0] ra_base_i,
   input  logic [REG_AW-1:0] rb_base_i,
   input  logic [REG_AW-1:0] rt_base_i,
   output logic [REG_AW-1:0] rd_a_addr_o,
   input  logic [DATA_W-1:0] rd_a_data_i,
   output logic [REG_AW-1:0] rd_b_addr_o,
   input  logic [DATA_W-1:0] rd_b_data_i,
   output logic              wr_en_o,
   output logic [REG_AW-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              cr_we_o,
   output logic [CR_AW-1:0]  cr_idx_o,
   output logic [3:0]        cr_val_o,
   output logic [STEP_W-1:0] src_step_o,
   output logic [STEP_W-1:0] dst_step_o,
   output logic              busy_o,
   output logic              done_o
);
   localparam int OFF_W   = STEP_W + 3;
   localparam int CR_BASE = 8;

   if (DATA_W < 2) begin : g_bad_data
      $error("vec_elem_seq: DATA_W must be at least 2");
   end
   if (MAX_VL < 1) begin : g_bad_vl
      $error("vec_elem_seq: MAX_VL must be at least 1");
   end
   if (CR_AW < $clog2(MAX_VL + CR_BASE)) begin : g_bad_cr
      $error("vec_elem_seq: CR_AW too narrow for the condition index range");
   end
   if (VL_W < $clog2(MAX_VL + 1)) begin : g_bad_vlw
      $error("vec_elem_seq: VL_W too narrow for MAX_VL");
   end

   logic              busy, first_lane, last_lane;
   logic [STEP_W-1:0] src, dst;
   logic [1:0]        lane, lanes_m1;
   logic [MAX_VL-1:0] mask_q;
   logic              rc_q, and_q;
   logic [REG_AW-1:0] ra_q, rb_q, rt_q;
   logic [OFF_W-1:0]  off;
   logic [DATA_W-1:0] sum;
   logic              elem_on;
   cr_field_t         test, fold;

   vec_elem_step_ctrl #(
      .MAX_VL (MAX_VL),
      .VL_W   (VL_W),
      .STEP_W (STEP_W)
   ) step_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .vl_i         (vl_i),
      .lanes_m1_i   (subvl_i),
      .resume_i     (resume_step_i),
      .busy_o       (busy),
      .done_o       (done_o),
      .src_o        (src),
      .dst_o        (dst),
      .lane_o       (lane),
      .lanes_m1_o   (lanes_m1),
      .first_lane_o (first_lane),
      .last_lane_o  (last_lane)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         rc_q   <= 1'b0;
         and_q  <= 1'b0;
         ra_q   <= '0;
         rb_q   <= '0;
         rt_q   <= '0;
      end else if (start_i && !busy) begin
         mask_q <= pred_en_i ? pred_mask_i : '1;
         rc_q   <= rc_en_i;
         and_q  <= fold_and_i;
         ra_q   <= ra_base_i;
         rb_q   <= rb_base_i;
         rt_q   <= rt_base_i;
      end
   end

   always_comb begin
      off     = OFF_W'(src) * (OFF_W'(lanes_m1) + OFF_W'(1)) + OFF_W'(lane);
      sum     = rd_a_data_i + rd_b_data_i;
      elem_on = busy && mask_q[src];
   end

   vec_elem_lane_test #(.DATA_W(DATA_W)) test_i (
      .sum_i  (sum),
      .test_o (test)
   );

   vec_elem_fold fold_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv_i   (busy),
      .first_i (first_lane),
      .and_i   (and_q),
      .test_i  (test),
      .fold_o  (fold)
   );

   assign rd_a_addr_o = ra_q + REG_AW'(off);
   assign rd_b_addr_o = rb_q + REG_AW'(off);
   assign wr_en_o     = elem_on;
   assign wr_addr_o   = rt_q + REG_AW'(off);
   assign wr_data_o   = sum;
   assign cr_we_o     = elem_on && rc_q && last_lane;
   assign cr_idx_o    = CR_AW'(CR_BASE) + CR_AW'(dst);
   assign cr_val_o    = fold;
   assign src_step_o  = src;
   assign dst_step_o  = dst;
   assign busy_o      = busy;

   a_r6_cr_with_write: assert property (@(posedge clk) disable iff (!rst_n)
      cr_we_o |-> (wr_en_o && cr_idx_o >= CR_AW'(CR_BASE)));
   a_r7_so_clear: assert property (@(posedge clk) disable iff (!rst_n)
      cr_we_o |-> !cr_val_o[CR_SO]);
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!wr_en_o && !cr_we_o));
   a_r4_start_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |-> !wr_en_o);
endmodule

// File: tb/vec_elem_seq_tb.sv
module vec_elem_seq_tb_top;
   localparam int DATA_W = 64;
   localparam int REG_AW = 7;
   localparam int MAX_VL = 64;
   localparam int VL_W   = 7;
   localparam int STEP_W = 6;
   localparam int CR_AW  = 7;
   localparam int NREG   = 1 << REG_AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic              start_i = 1'b0;
   logic [VL_W-1:0]   vl_i = '0;
   logic [1:0]        subvl_i = '0;
   logic [STEP_W-1:0] resume_step_i = '0;
   logic              pred_en_i = 1'b0;
   logic [MAX_VL-1:0] pred_mask_i = '0;
   logic              rc_en_i = 1'b0;
   logic              fold_and_i = 1'b0;
   logic [REG_AW-1:0] ra_base_i = '0, rb_base_i = '0, rt_base_i = '0;
   logic [REG_AW-1:0] rd_a_addr, rd_b_addr, wr_addr;
   logic [DATA_W-1:0] rd_a_data, rd_b_data, wr_data;
   logic              wr_en, cr_we, busy, done;
   logic [CR_AW-1:0]  cr_idx;
   logic [3:0]        cr_val;
   logic [STEP_W-1:0] src_step, dst_step;

   logic [DATA_W-1:0] regs [NREG];
   assign rd_a_data = regs[rd_a_addr];
   assign rd_b_data = regs[rd_b_addr];

   int checks = 0;
   int failures = 0;

   vec_elem_seq #(
      .DATA_W(DATA_W), .REG_AW(REG_AW), .MAX_VL(MAX_VL),
      .VL_W(VL_W), .STEP_W(STEP_W), .CR_AW(CR_AW)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i),
      .subvl_i(subvl_i), .resume_step_i(resume_step_i),
      .pred_en_i(pred_en_i), .pred_mask_i(pred_mask_i),
      .rc_en_i(rc_en_i), .fold_and_i(fold_and_i),
      .ra_base_i(ra_base_i), .rb_base_i(rb_base_i), .rt_base_i(rt_base_i),
      .rd_a_addr_o(rd_a_addr), .rd_a_data_i(rd_a_data),
      .rd_b_addr_o(rd_b_addr), .rd_b_data_i(rd_b_data),
      .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
      .cr_we_o(cr_we), .cr_idx_o(cr_idx), .cr_val_o(cr_val),
      .src_step_o(src_step), .dst_step_o(dst_step),
      .busy_o(busy), .done_o(done)
   );

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // R7: [3] lt, [2] gt, [1] eq, [0] so=0
   function automatic logic [3:0] lane_test(input logic [63:0] v);
      if (v == 64'd0)  return 4'b0010;
      else if (v[63])  return 4'b1000;
      else             return 4'b0100;
   endfunction

   task automatic run(input int vl, input int lm1, input bit pen,
                      input logic [MAX_VL-1:0] mask, input bit rc, input bit fand,
                      input int ra, input int rb, input int rt, input int resume);
      logic [MAX_VL-1:0] meff;
      logic [3:0] acc;
      meff = pen ? mask : '1;
      @(negedge clk);
      vl_i = VL_W'(vl); subvl_i = 2'(lm1); pred_en_i = pen; pred_mask_i = mask;
      rc_en_i = rc; fold_and_i = fand; resume_step_i = STEP_W'(resume);
      ra_base_i = REG_AW'(ra); rb_base_i = REG_AW'(rb); rt_base_i = REG_AW'(rt);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      // scramble live inputs: the design must use the values latched at start
      pred_mask_i = {$urandom, $urandom};
      pred_en_i = 1'b1; rc_en_i = ~rc; fold_and_i = ~fand;
      ra_base_i = REG_AW'($urandom); rt_base_i = REG_AW'($urandom);
      for (int i = resume; i < vl; i++) begin
         acc = '0;
         for (int l = 0; l <= lm1; l++) begin
            int off;
            logic [63:0] s;
            logic [3:0] t;
            bit en, cw;
            off = i * (lm1 + 1) + l;
            s = regs[(ra + off) % NREG] + regs[(rb + off) % NREG];
            t = lane_test(s);
            acc = (l == 0) ? t : (fand ? (acc & t) : (acc | t));
            en = meff[i];
            cw = rc && en && (l == lm1);
            chk(resume > 0 ? "R4" : "R3", "src_step", 64'(src_step), 64'(i));
            chk("R3", "dst_step", 64'(dst_step), 64'(i));
            chk(pen ? "R2" : "R1", "wr_en", 64'(wr_en), 64'(en));
            chk("R5", "rd_a_addr", 64'(rd_a_addr), 64'((ra + off) % NREG));
            if (en) begin
               chk("R5", "wr_addr", 64'(wr_addr), 64'((rt + off) % NREG));
               chk("R5", "wr_data", wr_data, s);
            end
            chk(lm1 > 0 ? "R10" : "R6", "cr_we", 64'(cr_we), 64'(cw));
            if (cw) begin
               chk("R6", "cr_idx", 64'(cr_idx), 64'(8 + i));
               chk(lm1 > 0 ? "R8" : "R7", "cr_val", 64'(cr_val), 64'(acc));
            end
            chk("R9", "done early", 64'(done), 64'd0);
            @(negedge clk);
         end
      end
      chk("R9", "done", 64'(done), 64'd1);
      chk("R9", "step zero", 64'(src_step), 64'd0);
      chk("R2", "no write at done", 64'(wr_en), 64'd0);
      @(negedge clk);
      chk("R9", "done pulse width", 64'(done), 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL R9 watchdog: done actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      for (int k = 0; k < NREG; k++) begin
         int m;
         m = k % 3;
         if (k < 32 || k >= 64)  regs[k] = {$urandom, $urandom};
         else if (m == 0)        regs[k] = -regs[k - 32];
         else if (m == 1)        regs[k] = {$urandom, $urandom};
         else                    regs[k] = 64'($urandom % 5) - regs[k - 32];
      end
      repeat (3) @(negedge clk);
      chk("R9", "reset done", 64'(done), 64'd0);
      chk("R3", "reset step", 64'(src_step), 64'd0);
      chk("R2", "reset wr_en", 64'(wr_en), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // directed corners
      run(0, 0, 0, '0, 1, 0, 0, 32, 64, 0);              // empty loop
      run(4, 1, 0, '0, 1, 0, 0, 32, 64, 4);              // resume == VL
      run(6, 0, 0, '0, 1, 0, 0, 32, 64, 0);              // no predicate
      run(6, 0, 1, 64'b101001, 1, 0, 3, 35, 70, 0);      // masked elements
      run(8, 2, 1, 64'hF0, 1, 1, 0, 32, 90, 3);          // resume mid, AND fold
      run(8, 3, 0, '0, 1, 1, 0, 32, 64, 0);              // 4 lanes AND
      run(8, 3, 0, '0, 1, 0, 0, 32, 64, 0);              // 4 lanes OR
      run(5, 1, 0, '0, 0, 0, 0, 32, 64, 0);              // rc off
      run(3, 0, 0, '0, 1, 0, 120, 20, 125, 0);           // address wrap
      // random mix
      for (int n = 0; n < 40; n++) begin
         int vl, lm1, ra;
         vl  = $urandom % 9;
         lm1 = $urandom % 4;
         ra  = $urandom % 32;
         run(vl, lm1, $urandom % 2, {$urandom, $urandom}, ($urandom % 4) != 0,
             $urandom % 2, ra, (($urandom % 4) == 0) ? ($urandom % NREG) : ra + 32,
             $urandom % NREG, ($urandom % 3 == 0) ? ($urandom % 9) : 0);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule